// File: doc/BRIEF.md
# I2C Address Frame Sender

This block is the address-phase engine of a simple I2C master. A single start request sends a start condition on the bus. It then shifts out one eight-bit frame and samples the acknowledge in a ninth clock slot. The frame holds a seven-bit target address in its upper bits and the read/write direction in bit 0. Both bus lines are open-drain: the block asserts an output enable to pull a line low, and releases the enable to let the line float high.

The serial clock comes from the operation clock. A divider value is captured when a start request is accepted, and each half period of SCL lasts that value plus one cycle. A divider of 0 is raised to 1, so the fastest serial clock is the operation clock divided by four. Software must pick a divider that keeps SCL within 100 kHz in standard mode or 400 kHz in fast mode.

When the frame ends, the block gives a one-cycle transfer-end interrupt. A sticky acknowledge-error flag records a target that did not acknowledge. The block has no other interrupt and does not generate a stop condition.

Top module: `i2c_addr_sender`

## Requirements
- R1: After reset, both output enables are 0 (lines released), and `busy_o`, `done_irq_o` and `ack_err_o` are 0.
- R2: An accepted start first pulls SDA low while SCL is released. SCL is first pulled low one half period later, which is (divider+1) cycles after SDA fell.
- R3: The frame goes out MSB first: `frame_i[7:1]` is the address, `frame_i[0]` is the direction bit, and the frame is captured at the accepted start. After the start condition, SDA changes only while SCL is low.
- R4: In the ninth SCL slot the block releases SDA. It samples the line at the end of the high half of that slot, and a high level (no acknowledge) sets `ack_err_o`.
- R5: A frame that is acknowledged (line low in the ninth slot) leaves a clear `ack_err_o` clear.
- R6: Once set, `ack_err_o` stays set through later frames, including acknowledged ones, until `ack_err_clr_i` is pulsed.
- R7: A one-cycle pulse on `ack_err_clr_i` clears `ack_err_o`, unless a no-acknowledge is sampled in the same cycle.
- R8: When the ninth slot ends, `done_irq_o` is high for exactly one cycle, and `busy_o` falls in that same cycle.
- R9: `busy_o` is high from the cycle after a start is accepted until the transfer-end pulse.
- R10: A start request while `busy_o` is high has no effect: the frame in progress completes unchanged, and no second frame follows.
- R11: The SCL period is 2×(divider+1) operation clock cycles, using the divider captured at the accepted start.
- R12: A divider of 0 acts as 1, giving the minimum SCL period of 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse, accepted only when idle |
| frame_i | input | 8 | Address in bits 7:1, direction in bit 0 |
| div_i | input | 7 | Half-period divider; a half period lasts div_i+1 cycles (0 acts as 1) |
| ack_err_clr_i | input | 1 | Pulse that clears the acknowledge-error flag |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Frame in progress |
| done_irq_o | output | 1 | One-cycle transfer-end interrupt |
| ack_err_o | output | 1 | Sticky no-acknowledge flag |

## Verification
The bench decodes the bus as an I2C target would, so a design that shifts LSB first or drops the direction bit delivers the wrong byte. A design that moves SDA while SCL is high shows up as a spurious start or stop. The bench measures the start hold time and every SCL period across several dividers, including 0. An unclamped divider would give a two-cycle clock, and a divider that is not captured at the start would stretch the period. A start request in the middle of a frame would restart or corrupt the frame if it were not ignored. The error flag is checked through a no-acknowledge, a later acknowledged frame and a clear pulse, so a flag that is not sticky, or that a new frame clears, is caught.

// File: rtl/i2c_addr_sender_pkg.sv
package i2c_addr_sender_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_LOW   = 2'd2,
    PH_HIGH  = 2'd3
  } phase_t;
endpackage

// File: rtl/i2c_half_tick.sv
module i2c_half_tick #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] lim_q, lim_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             lim_en;

  // a divider of 0 is raised to 1 so that each half period lasts at least two cycles
  assign lim_en = load;
  assign lim_d  = (div == '0) ? DIV_W'(1) : div;
  assign tick   = run && (cnt_q == lim_q);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= DIV_W'(1);
      cnt_q <= '0;
    end else begin
      if (lim_en) lim_q <= lim_d;
      cnt_q <= cnt_d;
    end
  end

  // R12
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
  import i2c_addr_sender_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick,
  input  logic               sda_s,
  input  logic               ack_err_clr_i,
  output logic               load,
  output logic               run,
  output logic               scl_oe,
  output logic               sda_oe,
  output logic               done,
  output logic               ack_err
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(FRAME_W);

  phase_t             st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   bit_q, bit_d;
  logic               scl_q, scl_d, sda_q, sda_d;
  logic               done_q, done_d, err_q, err_d, nack_set;

  assign load = (st_q == PH_IDLE) && start_i;

  always_comb begin
    st_d     = st_q;
    sh_d     = sh_q;
    bit_d    = bit_q;
    done_d   = 1'b0;
    nack_set = 1'b0;
    case (st_q)
      PH_IDLE: if (start_i) begin
        st_d  = PH_START;
        sh_d  = frame_i;
        bit_d = '0;
      end
      PH_START: if (tick) st_d = PH_LOW;
      PH_LOW:   if (tick) st_d = PH_HIGH;
      PH_HIGH: if (tick) begin
        if (bit_q == ACK_SLOT) begin
          st_d     = PH_IDLE;
          done_d   = 1'b1;
          nack_set = sda_s;
        end else begin
          st_d  = PH_LOW;
          bit_d = bit_q + CNT_W'(1);
          sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
        end
      end
      default: st_d = PH_IDLE;
    endcase

    scl_d = (st_d == PH_LOW);
    // SDA moves only in the start entry or while SCL is already held low
    if (load)                 sda_d = 1'b1;
    else if (st_q == PH_LOW)  sda_d = (bit_q == ACK_SLOT) ? 1'b0 : !sh_q[FRAME_W-1];
    else                      sda_d = sda_q;

    if (nack_set)           err_d = 1'b1;
    else if (ack_err_clr_i) err_d = 1'b0;
    else                    err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign run     = (st_q != PH_IDLE);
  assign scl_oe  = scl_q;
  assign sda_oe  = sda_q;
  assign done    = done_q;
  assign ack_err = err_q;

  // R3
  sda_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_q && !$past(scl_q) && (sda_q != $past(sda_q))) |-> (st_q == PH_START));
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PH_LOW) || (st_q == PH_HIGH)) |=> (st_q != PH_START));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !ack_err_clr_i) |=> err_q);
  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_err_clr_i && !nack_set) |=> !err_q);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) == 1'b0) |-> (st_q == PH_START));
endmodule

// File: rtl/i2c_addr_sender.sv
module i2c_addr_sender #(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               ack_err_clr_i,
  input  logic               sda_i,
  output logic               scl_oe_o,
  output logic               sda_oe_o,
  output logic               busy_o,
  output logic               done_irq_o,
  output logic               ack_err_o
);
  logic sda_m, sda_s;
  logic load, run, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_m <= 1'b1;
      sda_s <= 1'b1;
    end else begin
      sda_m <= sda_i;
      sda_s <= sda_m;
    end
  end

  i2c_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk (clk),
    .rst_n (rst_n),
    .load (load),
    .div (div_i),
    .run (run),
    .tick (tick)
  );

  i2c_addr_fsm #(.FRAME_W(FRAME_W)) u_fsm (
    .clk (clk),
    .rst_n (rst_n),
    .start_i (start_i),
    .frame_i (frame_i),
    .tick (tick),
    .sda_s (sda_s),
    .ack_err_clr_i (ack_err_clr_i),
    .load (load),
    .run (run),
    .scl_oe (scl_oe_o),
    .sda_oe (sda_oe_o),
    .done (done_irq_o),
    .ack_err (ack_err_o)
  );

  assign busy_o = run;
endmodule

// File: tb/i2c_addr_sender_test.sv
module i2c_addr_sender_test;
  typedef struct { logic [7:0] f; int per; } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, ack_err_clr_i;
  logic [7:0] frame_i;
  logic [6:0] div_i;
  logic scl_oe, sda_oe, busy, done_irq, ack_err;
  logic slv_drive, ack_en;
  logic scl_line, sda_line;

  int checks = 0, errors = 0, done_cnt = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slv_drive);

  i2c_addr_sender uut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .frame_i (frame_i),
    .div_i (div_i), .ack_err_clr_i (ack_err_clr_i), .sda_i (sda_line),
    .scl_oe_o (scl_oe), .sda_oe_o (sda_oe), .busy_o (busy),
    .done_irq_o (done_irq), .ack_err_o (ack_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: decodes the bus as a target would and scores against the queue
  logic psc = 1'b1, psd = 1'b1, pbusy = 1'b0;
  int nbits, rcnt, startcnt, viol, cur_per;
  logic fell;
  logic [7:0] rx;
  always @(negedge clk) begin
    logic sc, sd;
    sc = scl_line;
    sd = sda_line;
    if (rst_n) begin
      if (done_irq) begin
        done_cnt++;
        slv_drive = 1'b0;
        chk(viol == 0, "R3 sda moved while scl high", viol, 0);
      end
      if (busy && !pbusy) begin
        nbits = 0; rcnt = 0; startcnt = 0; viol = 0; fell = 1'b0;
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected frame", 1, 0);
          cur_per = 0;
        end else cur_per = q[0].per;
      end
      if (busy) begin
        rcnt++;
        if (!fell && sc && !sd) startcnt++;
        if (psc && !sc && !fell) begin
          fell = 1'b1;
          chk(startcnt == cur_per / 2, "R2 start hold", startcnt, cur_per / 2);
        end
        if (pbusy && psc && sc && (sd != psd)) viol++;
        if (!psc && sc) begin
          nbits++;
          if (nbits > 1)
            chk(rcnt == cur_per, "R11/R12 scl period", rcnt, cur_per);
          rcnt = 0;
          if (nbits <= 8) rx = {rx[6:0], sd};
          if (nbits == 8 && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(rx == e.f, "R3 frame byte", rx, e.f);
          end
        end
        if (psc && !sc && nbits == 8) slv_drive = ack_en;
      end
    end
    psc = sc; psd = sd; pbusy = busy;
  end

  task automatic send(input logic [7:0] f, input logic [6:0] d, input logic ack,
                      input logic exp_err, input bit poke);
    exp_t e;
    int start_done, t;
    int lim;
    lim = (d == 0) ? 1 : int'(d);
    e.f = f;
    e.per = 2 * (lim + 1);
    @(negedge clk);
    frame_i = f; div_i = d; ack_en = ack;
    q.push_back(e);
    start_done = done_cnt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    frame_i = ~f;
    div_i = 7'd9;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    if (poke) begin
      repeat (3 * e.per) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy == 1'b1, "R10 busy kept", busy, 1);
    end
    t = 0;
    while (!done_irq && t < 5000) begin
      @(negedge clk);
      t++;
      if (!done_irq) chk(busy == 1'b1, "R9 busy held", busy, 1);
    end
    chk(done_irq == 1'b1, "R8 done seen", done_irq, 1);
    chk(busy == 1'b0, "R8 busy falls with done", busy, 0);
    chk(ack_err == exp_err, "R4/R5/R6 ack error flag", ack_err, exp_err);
    @(negedge clk);
    chk(done_irq == 1'b0, "R8 done one cycle", done_irq, 0);
    chk(done_cnt == start_done + 1, "R8 done count", done_cnt, start_done + 1);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && scl_oe == 1'b0, "R10 no second frame", busy, 0);
  endtask

  initial begin
    slv_drive = 1'b0; ack_en = 1'b1;
    start_i = 1'b0; ack_err_clr_i = 1'b0; frame_i = '0; div_i = 7'd1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(busy == 0 && done_irq == 0 && ack_err == 0, "R1 status clear",
        {busy, done_irq, ack_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(8'hA4, 7'd1, 1'b1, 1'b0, 1'b0);   // R5 acked frame, error stays clear
    send(8'h3B, 7'd3, 1'b0, 1'b1, 1'b0);   // R4 no acknowledge sets flag
    send(8'h81, 7'd0, 1'b1, 1'b1, 1'b0);   // R6 sticky through acked frame, R12 div 0
    @(negedge clk);
    ack_err_clr_i = 1'b1;
    @(negedge clk);
    ack_err_clr_i = 1'b0;
    chk(ack_err == 1'b0, "R7 clear pulse", ack_err, 0);
    send(8'h5E, 7'd5, 1'b1, 1'b0, 1'b1);   // R10 start while busy ignored, R11
    send(8'h01, 7'd2, 1'b0, 1'b1, 1'b0);   // R4 again with direction bit set
    chk(q.size() == 0, "R3 all frames seen", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule